// File: doc/BRIEF.md
# Dual-Clock Read Buffer with Separate Flush and Cancel

This block sits between a memory-side engine and a client that consumes read data. The memory side pushes words into a dual-clock FIFO in the core clock domain. The client pops words in its own read clock domain, which may have no phase or frequency relation to the core clock. The write and read pointers cross between the domains as Gray code through two-stage synchronizers. The client sees a registered data output, an empty flag and an almost-empty flag. A beat counter shows where the current 32-word burst stands, and a client can close a short burst by raising a burst-end strobe together with its last pop.

Two clear inputs act on the buffer. Both may be driven from any domain. `ctl_reset` cancels the active read command and drops all buffered words. `ctl_flush` drops all buffered words but leaves the active command in place. A single command register marks whether a read command is in flight. Each clear input is synchronized into both domains and zeroes the pointer of each domain. The block then reports busy for a fixed quiet window. During that window writes, pops and command starts are ignored, and the read-side flags stay forced high.

Top module: `frb_rd_buffer`

## Requirements
- R1: Words leave in the order they were written. A pop accepted at a read-clock rising edge places the word on `rd_data` at that same edge, one cycle after the cycle in which `rd_pop` was high.
- R2: `rd_empty` is high whenever no written word remains unread. It is high after power-on reset, and it is never low while the FIFO holds nothing. `rd_data` is zero after power-on reset.
- R3: `rd_aempty` is high whenever the occupancy is at or below `AE_TH`, is low only when the occupancy exceeds `AE_TH`, and is always high while `rd_empty` is high.
- R4: `wr_full` goes high once `DEPTH` unread words are stored. A write presented while full is dropped and never overwrites stored data.
- R5: A pop while `rd_empty` is high is ignored. The read pointer does not move and `rd_data` keeps its previous value.
- R6: A flush leaves the FIFO empty, and the next word written is the next word read. `core_cmd_active` is not changed by a flush.
- R7: A reset request leaves the FIFO empty and clears `core_cmd_active`, even if the command had not finished.
- R8: After a clear input is released, `core_busy` stays high until the 8th core-clock rising edge: two synchronizer stages plus 6 quiet cycles. Writes presented while `core_busy` is high are dropped. While `rd_busy` is high, `rd_empty` and `rd_aempty` are both high and pops are ignored.
- R9: `rd_beat` counts accepted pops from 0 to 31 and wraps to 0. An accepted pop with `rd_end_burst` high returns it to 0. Any clear also returns it to 0.
- R10: A `cmd_start` pulse seen while `core_busy` is low sets `core_cmd_active` at the next core-clock edge. A pulse seen while `core_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core (memory side) clock |
| core_rst_n | input | 1 | Core-domain reset, active low; asserts asynchronously and is released synchronously |
| rd_clk | input | 1 | Client read clock |
| rd_rst_n | input | 1 | Read-domain reset, active low; asserts asynchronously and is released synchronously |
| ctl_reset | input | 1 | Clear request that drops data and cancels the command; hold for at least two core cycles |
| ctl_flush | input | 1 | Clear request that drops data and keeps the command; hold for at least two core cycles |
| cmd_start | input | 1 | Core-domain strobe that marks a read command active |
| core_cmd_active | output | 1 | Read command in flight |
| core_busy | output | 1 | Core side is clearing or in its quiet window |
| wr_en | input | 1 | Write strobe from the memory side |
| wr_data | input | DW | Write word |
| wr_full | output | 1 | FIFO holds DEPTH words |
| rd_pop | input | 1 | Client pop strobe |
| rd_end_burst | input | 1 | Marks the last pop of a short burst |
| rd_data | output | DW | Registered read word |
| rd_empty | output | 1 | No word available |
| rd_aempty | output | 1 | Occupancy at or below AE_TH |
| rd_beat | output | 5 | Index of the next pop within the current burst |
| rd_busy | output | 1 | Read side not ready after a clear |

## Verification
Several traffic patterns exercise the main path, and each separates different faults. Bursts written with no pops and then drained expose overwrite-when-full faults and pointer wrap faults. A single fill to just above the threshold, followed by single pops, finds where the almost-empty flag switches. Interleaved writes and pops with irregular gaps, run while the two clocks drift against each other, test the Gray-code crossing and the read-data latency. A burst-end strobe placed mid-stream shows an early burst close apart from the normal wrap at 32. Flush and reset runs, with data pending and a command active, distinguish the two clear kinds. Writes and command strobes are also issued inside the quiet window to show that they are refused.

// File: rtl/frb_pkg.sv
package frb_pkg;
  // Words per burst on the client side; beat counter width follows.
  localparam int unsigned BURST_WORDS  = 32;
  localparam int unsigned BEAT_W       = $clog2(BURST_WORDS);
  // Core-clock cycles of refusal after a clear is released.
  localparam int unsigned QUIET_CYCLES = 6;
  localparam int unsigned QUIET_W      = $clog2(QUIET_CYCLES + 1);

  // Synchronized clear requests as seen inside one clock domain.
  typedef struct packed {
    logic cancel;   // drop data and the active command
    logic drop;     // drop data only
  } clr_req_t;
endpackage

// File: rtl/frb_sync.sv
// Two-stage synchronizer; with d tied high it serves as a reset-release synchronizer.
module frb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/frb_ram.sv
// Flop storage written in the core domain, read combinationally by the read domain.
module frb_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/frb_wr_ctrl.sv
// Core-domain side: write pointer, full flag, quiet-window counter, command register.
module frb_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  frb_pkg::clr_req_t   clr,
  input  logic                wr_en,
  input  logic                cmd_start,
  input  logic [AW:0]         rptr_gray_s,
  output logic [AW:0]         wptr_bin,
  output logic [AW:0]         wptr_gray,
  output logic                mem_we,
  output logic                full,
  output logic                busy,
  output logic                cmd_active
);
  import frb_pkg::*;

  localparam int PW = AW + 1;

  logic [PW-1:0]      wbin_q, wbin_d;
  logic [PW-1:0]      wgray_q, wgray_d;
  logic [QUIET_W-1:0] quiet_q, quiet_d;
  logic               cmd_q, cmd_d;
  logic [PW-1:0]      rbin_s;
  logic               clr_any;
  logic               accept;

  // Gray to binary for the synchronized read pointer.
  always_comb begin
    rbin_s[PW-1] = rptr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      rbin_s[i] = rbin_s[i+1] ^ rptr_gray_s[i];
    end
  end

  assign clr_any = clr.cancel | clr.drop;
  assign busy    = clr_any | (quiet_q != '0);
  assign full    = (wbin_q[PW-1] != rbin_s[PW-1]) &&
                   (wbin_q[PW-2:0] == rbin_s[PW-2:0]);
  assign accept  = wr_en & ~full & ~busy;

  always_comb begin
    wbin_d  = wbin_q;
    quiet_d = quiet_q;
    cmd_d   = cmd_q;
    if (clr_any) begin
      wbin_d  = '0;
      quiet_d = QUIET_W'(QUIET_CYCLES);
    end else begin
      if (quiet_q != '0) begin
        quiet_d = quiet_q - 1'b1;
      end
      if (accept) begin
        wbin_d = wbin_q + 1'b1;
      end
    end
    if (clr.cancel) begin
      cmd_d = 1'b0;
    end else if (cmd_start && !busy) begin
      cmd_d = 1'b1;
    end
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      quiet_q <= '0;
      cmd_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      quiet_q <= quiet_d;
      cmd_q   <= cmd_d;
    end
  end

  assign wptr_bin   = wbin_q;
  assign wptr_gray  = wgray_q;
  assign mem_we     = accept;
  assign cmd_active = cmd_q;
endmodule

// File: rtl/frb_rd_ctrl.sv
// Read-domain side: read pointer, flags, output register, burst beat counter.
module frb_rd_ctrl #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int AE_TH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  frb_pkg::clr_req_t          clr,
  input  logic                       core_busy_s,
  input  logic [AW:0]                wptr_gray_s,
  input  logic                       pop,
  input  logic                       end_burst,
  input  logic [DW-1:0]              mem_rdata,
  output logic [AW-1:0]              raddr,
  output logic [AW:0]                rptr_gray,
  output logic [DW-1:0]              data,
  output logic                       empty,
  output logic                       aempty,
  output logic [frb_pkg::BEAT_W-1:0] beat,
  output logic                       busy
);
  import frb_pkg::*;

  localparam int PW = AW + 1;

  logic [PW-1:0]     rbin_q, rbin_d;
  logic [PW-1:0]     rgray_q, rgray_d;
  logic [DW-1:0]     data_q, data_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [PW-1:0]     wbin_s;
  logic [PW-1:0]     level;
  logic              clr_any;
  logic              accept;

  always_comb begin
    wbin_s[PW-1] = wptr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      wbin_s[i] = wbin_s[i+1] ^ wptr_gray_s[i];
    end
  end

  assign clr_any = clr.cancel | clr.drop;
  assign busy    = clr_any | core_busy_s;
  assign level   = wbin_s - rbin_q;
  assign empty   = busy | (level == '0);
  assign aempty  = busy | (level <= PW'(AE_TH));
  assign accept  = pop & ~empty;

  always_comb begin
    rbin_d = rbin_q;
    data_d = data_q;
    beat_d = beat_q;
    if (clr_any) begin
      rbin_d = '0;
      beat_d = '0;
    end else if (accept) begin
      rbin_d = rbin_q + 1'b1;
      data_d = mem_rdata;
      if (end_burst || (beat_q == BEAT_W'(BURST_WORDS - 1))) begin
        beat_d = '0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      beat_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      data_q  <= data_d;
      beat_q  <= beat_d;
    end
  end

  assign raddr     = rbin_q[AW-1:0];
  assign rptr_gray = rgray_q;
  assign data      = data_q;
  assign beat      = beat_q;
endmodule

// File: rtl/frb_rd_buffer.sv
module frb_rd_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AE_TH = 4
) (
  input  logic          core_clk,
  input  logic          core_rst_n,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          ctl_reset,
  input  logic          ctl_flush,
  input  logic          cmd_start,
  output logic          core_cmd_active,
  output logic          core_busy,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_pop,
  input  logic          rd_end_burst,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_aempty,
  output logic [4:0]    rd_beat,
  output logic          rd_busy
);
  import frb_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          core_srst_n;
  logic          rd_srst_n;
  logic [1:0]    core_clr_raw;
  logic [1:0]    rd_clr_raw;
  clr_req_t      core_clr;
  clr_req_t      rd_clr;
  logic [PW-1:0] wptr_bin;
  logic [PW-1:0] wptr_gray;
  logic [PW-1:0] wptr_gray_s;
  logic [PW-1:0] rptr_gray;
  logic [PW-1:0] rptr_gray_s;
  logic          core_busy_s;
  logic          mem_we;
  logic [AW-1:0] raddr;
  logic [DW-1:0] mem_rdata;

  // Reset release synchronizers.
  frb_sync #(.W(1)) i_core_rst (
    .clk(core_clk), .rst_n(core_rst_n), .d(1'b1), .q(core_srst_n)
  );
  frb_sync #(.W(1)) i_rd_rst (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(rd_srst_n)
  );

  // Clear requests into each domain.
  frb_sync #(.W(2)) i_core_clr (
    .clk(core_clk), .rst_n(core_srst_n), .d({ctl_reset, ctl_flush}), .q(core_clr_raw)
  );
  frb_sync #(.W(2)) i_rd_clr (
    .clk(rd_clk), .rst_n(rd_srst_n), .d({ctl_reset, ctl_flush}), .q(rd_clr_raw)
  );
  assign core_clr = clr_req_t'(core_clr_raw);
  assign rd_clr   = clr_req_t'(rd_clr_raw);

  // Pointer and status crossings.
  frb_sync #(.W(PW)) i_wptr_x (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wptr_gray), .q(wptr_gray_s)
  );
  frb_sync #(.W(PW)) i_rptr_x (
    .clk(core_clk), .rst_n(core_srst_n), .d(rptr_gray), .q(rptr_gray_s)
  );
  frb_sync #(.W(1)) i_busy_x (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(core_busy), .q(core_busy_s)
  );

  frb_wr_ctrl #(.AW(AW)) i_wr (
    .clk         (core_clk),
    .rst_n       (core_srst_n),
    .clr         (core_clr),
    .wr_en       (wr_en),
    .cmd_start   (cmd_start),
    .rptr_gray_s (rptr_gray_s),
    .wptr_bin    (wptr_bin),
    .wptr_gray   (wptr_gray),
    .mem_we      (mem_we),
    .full        (wr_full),
    .busy        (core_busy),
    .cmd_active  (core_cmd_active)
  );

  frb_ram #(.DW(DW), .AW(AW)) i_ram (
    .wclk  (core_clk),
    .we    (mem_we),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_rdata)
  );

  frb_rd_ctrl #(.DW(DW), .AW(AW), .AE_TH(AE_TH)) i_rd (
    .clk         (rd_clk),
    .rst_n       (rd_srst_n),
    .clr         (rd_clr),
    .core_busy_s (core_busy_s),
    .wptr_gray_s (wptr_gray_s),
    .pop         (rd_pop),
    .end_burst   (rd_end_burst),
    .mem_rdata   (mem_rdata),
    .raddr       (raddr),
    .rptr_gray   (rptr_gray),
    .data        (rd_data),
    .empty       (rd_empty),
    .aempty      (rd_aempty),
    .beat        (rd_beat),
    .busy        (rd_busy)
  );
endmodule

// File: rtl/frb_checker.sv
module frb_checker #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic              core_clk,
  input logic              core_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input frb_pkg::clr_req_t core_clr,
  input logic              core_cmd_active,
  input logic              core_busy,
  input logic              wr_full,
  input logic [AW:0]       wptr_bin,
  input logic              rd_pop,
  input logic              rd_end_burst,
  input logic [DW-1:0]     rd_data,
  input logic              rd_empty,
  input logic              rd_aempty,
  input logic [4:0]        rd_beat
);
  logic clr_any;
  assign clr_any = core_clr.cancel | core_clr.drop;

  a_r3_empty_implies_aempty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> rd_aempty);

  a_r5_hold_on_empty_pop: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_pop && rd_empty) |=> $stable(rd_data));

  a_r9_end_burst_restarts: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_pop && rd_end_burst && !rd_empty) |=> (rd_beat == 5'd0));

  a_r4_no_write_when_full: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (wr_full && !clr_any) |=> $stable(wptr_bin));

  a_r7_cancel_drops_cmd: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_clr.cancel |=> !core_cmd_active);

  a_r6_flush_keeps_cmd: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (core_clr.drop && !core_clr.cancel && core_cmd_active) |=> core_cmd_active);

  a_r8_quiet_after_clear: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    $fell(clr_any) |-> core_busy);
endmodule

bind frb_rd_buffer frb_checker #(.DW(DW), .AW(AW)) i_frb_checker (
  .core_clk        (core_clk),
  .core_rst_n      (core_srst_n),
  .rd_clk          (rd_clk),
  .rd_rst_n        (rd_srst_n),
  .core_clr        (core_clr),
  .core_cmd_active (core_cmd_active),
  .core_busy       (core_busy),
  .wr_full         (wr_full),
  .wptr_bin        (wptr_bin),
  .rd_pop          (rd_pop),
  .rd_end_burst    (rd_end_burst),
  .rd_data         (rd_data),
  .rd_empty        (rd_empty),
  .rd_aempty       (rd_aempty),
  .rd_beat         (rd_beat)
);

// File: tb/test_frb_rd_buffer.sv
module test_frb_rd_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AE_TH = 4;

  logic          core_clk, core_rst_n, rd_clk, rd_rst_n;
  logic          ctl_reset, ctl_flush, cmd_start;
  logic          core_cmd_active, core_busy;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          wr_full;
  logic          rd_pop, rd_end_burst;
  logic [DW-1:0] rd_data;
  logic          rd_empty, rd_aempty, rd_busy;
  logic [4:0]    rd_beat;

  frb_rd_buffer #(.DW(DW), .DEPTH(DEPTH), .AE_TH(AE_TH)) i_frb_rd_buffer (
    .core_clk(core_clk), .core_rst_n(core_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .ctl_reset(ctl_reset), .ctl_flush(ctl_flush), .cmd_start(cmd_start),
    .core_cmd_active(core_cmd_active), .core_busy(core_busy),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_pop(rd_pop), .rd_end_burst(rd_end_burst), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty), .rd_beat(rd_beat), .rd_busy(rd_busy)
  );

  initial core_clk = 1'b0;
  always #(CLK_PERIOD/2) core_clk = ~core_clk;
  initial rd_clk = 1'b0;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  // Reference model state
  logic [DW-1:0] q[$];
  int            n_cmp = 0;
  int            n_mis = 0;
  int            n_written = 0;
  int            n_popped = 0;
  bit            mon_on = 0;
  bit            pend = 0;
  bit            hold_pend = 0;
  logic [DW-1:0] exp_data;
  logic [DW-1:0] hold_val;
  int            beat_m = 0;
  bit            cmd_m = 0;
  bit            rst_kind = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Read-side reference, compared on every read clock
  always @(negedge rd_clk) begin
    if (mon_on) begin
      if (pend) begin
        check(rd_data == exp_data, "R1", "popped word", rd_data, exp_data);
        pend = 0;
      end else if (hold_pend) begin
        check(rd_data == hold_val, "R5", "data held on empty pop", rd_data, hold_val);
        hold_pend = 0;
      end
      if (rd_busy) begin
        check(rd_empty && rd_aempty, "R8", "flags forced while busy",
              {rd_empty, rd_aempty}, 2'b11);
        q.delete();
        beat_m = 0;
      end else begin
        if (q.size() == 0) check(rd_empty, "R2", "empty when nothing stored", rd_empty, 1);
        if (!rd_empty) check(q.size() > 0, "R2", "not empty needs data", q.size(), 1);
        if (q.size() <= AE_TH) check(rd_aempty, "R3", "aempty at low level", rd_aempty, 1);
        if (!rd_aempty) check(q.size() > AE_TH, "R3", "aempty low needs level", q.size(), AE_TH + 1);
        check(rd_beat == 5'(beat_m), "R9", "beat index", rd_beat, beat_m);
      end
      if (rd_pop && !rd_empty && !rd_busy) begin
        if (q.size() > 0) begin
          exp_data = q.pop_front();
          pend = 1;
        end
        n_popped++;
        beat_m = (rd_end_burst || beat_m == 31) ? 0 : beat_m + 1;
      end else if (rd_pop) begin
        hold_pend = 1;
        hold_val  = rd_data;
      end
    end
  end

  // Core-side reference
  always @(negedge core_clk) begin
    if (mon_on) begin
      if (core_busy) begin
        if (rst_kind) cmd_m = 0;
      end else begin
        check(core_cmd_active == cmd_m, "R10", "command flag", core_cmd_active, cmd_m);
      end
      check(q.size() <= DEPTH, "R4", "no overflow", q.size(), DEPTH);
      if (wr_en && !wr_full && !core_busy) begin
        q.push_back(wr_data);
        n_written++;
      end
      if (cmd_start && !core_busy) cmd_m = 1;
    end
  end

  task automatic push_words(input int n, input int gap_mod);
    int target = n_written + n;
    int cyc = 0;
    forever begin
      @(posedge core_clk); #1;
      if (n_written >= target) begin
        wr_en = 1'b0;
        break;
      end
      wr_en   = !(gap_mod > 0 && (cyc % gap_mod) == 0);
      wr_data = 32'hC0DE_0000 ^ 32'(n_written * 7 + 1);
      cyc++;
    end
  endtask

  task automatic pop_words(input int n, input int gap_mod, input int eb_at);
    int target = n_popped + n;
    int cyc = 0;
    forever begin
      @(posedge rd_clk); #1;
      if (n_popped >= target) begin
        rd_pop = 1'b0;
        rd_end_burst = 1'b0;
        break;
      end
      rd_pop       = !(gap_mod > 0 && (cyc % gap_mod) == 0);
      rd_end_burst = (n_popped == eb_at);
      cyc++;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  task automatic pulse_cmd();
    @(posedge core_clk); #1; cmd_start = 1'b1;
    @(posedge core_clk); #1; cmd_start = 1'b0;
  endtask

  task automatic do_clear(input bit is_cancel);
    int busy_cyc = 0;
    rst_kind = is_cancel;
    @(posedge rd_clk); #1;
    if (is_cancel) ctl_reset = 1'b1; else ctl_flush = 1'b1;
    repeat (6) @(posedge rd_clk);
    #1;
    ctl_reset = 1'b0;
    ctl_flush = 1'b0;
    // Count core edges still busy; try writes and command strobes meanwhile.
    forever begin
      @(posedge core_clk); #1;
      if (!core_busy) begin
        wr_en = 1'b0;
        cmd_start = 1'b0;
        break;
      end
      busy_cyc++;
      wr_en     = 1'b1;
      wr_data   = 32'hDEAD_0000 | 32'(busy_cyc);
      cmd_start = is_cancel;
    end
    check(busy_cyc == 7, "R8", "quiet window length", busy_cyc, 7);
    while (rd_busy) @(negedge rd_clk);
    settle();
    check(rd_empty == 1'b1, is_cancel ? "R7" : "R6", "empty after clear", rd_empty, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    core_rst_n = 1'b0; rd_rst_n = 1'b0;
    ctl_reset = 1'b0; ctl_flush = 1'b0; cmd_start = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_pop = 1'b0; rd_end_burst = 1'b0;
    #100;
    core_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (5) @(posedge rd_clk);
    @(negedge rd_clk);
    // Reset state (R2)
    check(rd_empty && rd_aempty, "R2", "reset flags", {rd_empty, rd_aempty}, 2'b11);
    check(rd_data == '0, "R2", "reset data", rd_data, 0);
    check(!wr_full && !core_busy && !rd_busy && !core_cmd_active, "R2", "reset idle",
          {wr_full, core_busy, rd_busy, core_cmd_active}, 0);
    mon_on = 1;

    // R1: short transfer, gapped pops
    push_words(5, 0);
    settle();
    pop_words(5, 2, -1);
    settle();

    // R3: threshold crossing
    push_words(AE_TH + 1, 0);
    settle();
    check(!rd_aempty && !rd_empty, "R3", "above threshold", {rd_aempty, rd_empty}, 0);
    pop_words(1, 0, -1);
    settle();
    check(rd_aempty && !rd_empty, "R3", "at threshold", {rd_aempty, rd_empty}, 2'b10);
    pop_words(AE_TH, 0, -1);
    settle();

    // R5: pops while empty
    hold_val = rd_data;
    @(posedge rd_clk); #1; rd_pop = 1'b1;
    repeat (5) @(posedge rd_clk);
    #1; rd_pop = 1'b0;
    @(negedge rd_clk);
    check(rd_data == hold_val, "R5", "data after empty pops", rd_data, hold_val);

    // R4: fill, overfill attempt, drain
    push_words(DEPTH, 0);
    settle();
    check(wr_full == 1'b1, "R4", "full at depth", wr_full, 1);
    check(q.size() == DEPTH, "R4", "model level", q.size(), DEPTH);
    @(posedge core_clk); #1; wr_en = 1'b1; wr_data = 32'hBAD0_0001;
    repeat (3) @(posedge core_clk);
    #1; wr_en = 1'b0;
    pop_words(DEPTH, 3, -1);
    settle();
    check(wr_full == 1'b0, "R4", "not full after drain", wr_full, 0);

    // R6: flush with data pending and command active
    pulse_cmd();
    push_words(5, 0);
    settle();
    do_clear(1'b0);
    check(core_cmd_active == 1'b1, "R6", "command kept by flush", core_cmd_active, 1);
    push_words(3, 0);
    settle();
    pop_words(3, 0, -1);
    settle();

    // R7: cancel with data pending; command strobes inside window ignored (R10)
    push_words(4, 0);
    settle();
    do_clear(1'b1);
    check(core_cmd_active == 1'b0, "R7", "command cancelled", core_cmd_active, 0);
    pulse_cmd();
    @(negedge core_clk);
    check(core_cmd_active == 1'b1, "R10", "command after quiet", core_cmd_active, 1);

    // R9: burst beat with early end, streamed with both sides gapped
    fork
      push_words(40, 3);
      pop_words(40, 4, n_popped + 5);
    join
    settle();
    check(rd_beat == 5'd2, "R9", "beat after early end and wrap", rd_beat, 2);

    // Longer mixed stream
    fork
      push_words(70, 5);
      pop_words(70, 2, n_popped + 50);
    join
    settle();
    check(rd_empty == 1'b1, "R2", "empty after stream", rd_empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule